// File: doc/BRIEF.md
# Memory-Mapped IO Decoder with Key-Protected Code-Write Port

This block sits on the data side of a small processor. It splits every load and store between data RAM and a small bank of IO registers. Only the low 17 bits of the address are used. When bit 16 of that value is clear, the access goes to RAM unchanged. When bit 16 is set, the access is served by the IO bank.

The IO bank holds five functions:
- a byte-wide console, with a transmit stream for stores and a receive byte for loads;
- a cycle timer that advances once per hundred clocks;
- a debug capture register;
- a sticky halt request;
- a code-memory write port guarded by a 32-bit key.

Once the key has been stored, each store to the port's data location becomes one single-cycle write on the code-memory bus. The held write address then steps by 4. Loads from IO locations that have no read function raise an illegal-access pulse. Stores to unknown IO locations are dropped without effect.

CPU-side reads are combinational in the request cycle. All IO side effects (console transmit, code write, halt, debug, illegal) appear on the outputs one clock after the request edge.

Top module: `mmio_decoder`

## Requirements
- R1: Only address bits 16:0 are used. With bit 16 clear, the request drives `ram_en_o` in the same cycle, with `ram_addr_o` = address[15:0], `ram_we_o` = the store flag, and `cpu_rdata_o` = `ram_rdata_i` on loads. Bits 31:17 never change the routing.
- R2: A store to 0x1FC80 sets the unlock flag if the data is 0x1337F7D1 and clears it for any other value. The flag is clear after reset.
- R3: A store to 0x1FC84 loads the code write address. Reset sets it to 0.
- R4: While unlocked, a store to 0x1FC88 makes `pm_we_o` high for exactly the next cycle, with `pm_addr_o` = the held address, `pm_wdata_o` = the store data and `pm_size_o` = the store size. The held address then increases by 4.
- R5: While locked, a store to 0x1FC88 produces no `pm_we_o` pulse and leaves the held address unchanged.
- R6: A load from 0x1FFF4 returns N/100 (integer division), where N is the number of clock edges since reset was released, counted up to the request cycle.
- R7: A store to 0x10000 gives a one-cycle `con_tx_valid_o` in the next cycle, with `con_tx_byte_o` = data[7:0].
- R8: A load from 0x10000 returns {24'b0, `con_rx_byte_i`} and asserts `con_rx_take_o` in the same cycle.
- R9: A store to 0x1FFFC sets `halt_o` from the next cycle on, and `halt_o` stays set until reset.
- R10: A store to 0x1FFF8 captures the data into `debug_o` in the next cycle.
- R11: A load from any IO address other than 0x10000 and 0x1FFF4 pulses `illegal_o` in the next cycle. The read data for that load is 0.
- R12: A store to an IO address with no function (including the timer address) changes none of `debug_o`, `halt_o`, `con_tx_valid_o`, `pm_we_o` or the timer value.
- R13: After reset, `pm_we_o`, `con_tx_valid_o`, `halt_o`, `illegal_o` are 0 and `debug_o` is 0.
- R14: An IO access never asserts `ram_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid_i | input | 1 | Request strobe |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_size_i | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_rdata_o | output | 32 | Load data, same cycle |
| ram_en_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write |
| ram_size_o | output | 2 | RAM access size |
| ram_addr_o | output | 16 | RAM byte address |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data |
| pm_we_o | output | 1 | Code-memory write pulse |
| pm_size_o | output | 2 | Code-memory write size |
| pm_addr_o | output | 32 | Code-memory write address |
| pm_wdata_o | output | 32 | Code-memory write data |
| con_tx_valid_o | output | 1 | Console transmit strobe |
| con_tx_byte_o | output | 8 | Console transmit byte |
| con_rx_byte_i | input | 8 | Console receive byte |
| con_rx_take_o | output | 1 | Console receive byte consumed |
| debug_o | output | 32 | Debug capture register |
| halt_o | output | 1 | Sticky halt request |
| illegal_o | output | 1 | Illegal IO load pulse |

## Verification
The timer read and the prescaler wrap can fall on the same clock edge. The bench waits until the hundredth edge of a period is about to come, then issues a timer load in exactly that cycle. It then checks that the value returned is the one before the increment, computed from its own edge count since reset. A second read one cycle later confirms the increment. Unlock, address load and data stores are also issued back to back, so the data store sees a flag and an address that were updated on the preceding edge.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;

    localparam int LOC_W  = 17;
    localparam int RAM_AW = 16;

    localparam logic [LOC_W-1:0] LOC_CONSOLE = 17'h10000;
    localparam logic [LOC_W-1:0] LOC_KEY     = 17'h1FC80;
    localparam logic [LOC_W-1:0] LOC_CW_ADDR = 17'h1FC84;
    localparam logic [LOC_W-1:0] LOC_CW_DATA = 17'h1FC88;
    localparam logic [LOC_W-1:0] LOC_TIMER   = 17'h1FFF4;
    localparam logic [LOC_W-1:0] LOC_DEBUG   = 17'h1FFF8;
    localparam logic [LOC_W-1:0] LOC_EXIT    = 17'h1FFFC;

    localparam logic [31:0] CODE_KEY = 32'h1337F7D1;

    typedef enum logic [3:0] {
        TGT_RAM,
        TGT_CONSOLE,
        TGT_KEY,
        TGT_CW_ADDR,
        TGT_CW_DATA,
        TGT_TIMER,
        TGT_DEBUG,
        TGT_EXIT,
        TGT_NONE
    } target_e;

    typedef struct packed {
        logic             valid;
        logic             we;
        logic [1:0]       size;
        logic [LOC_W-1:0] loc;
        logic [31:0]      data;
    } req_t;

    function automatic target_e classify(input logic [LOC_W-1:0] loc);
        if (!loc[LOC_W-1]) return TGT_RAM;
        case (loc)
            LOC_CONSOLE: return TGT_CONSOLE;
            LOC_KEY:     return TGT_KEY;
            LOC_CW_ADDR: return TGT_CW_ADDR;
            LOC_CW_DATA: return TGT_CW_DATA;
            LOC_TIMER:   return TGT_TIMER;
            LOC_DEBUG:   return TGT_DEBUG;
            LOC_EXIT:    return TGT_EXIT;
            default:     return TGT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_dec_pkg::*;
(
    input  req_t    req,
    output target_e tgt,
    output logic    is_load,
    output logic    is_store
);
    always_comb begin
        tgt      = classify(req.loc);
        is_load  = req.valid && !req.we;
        is_store = req.valid && req.we;
    end
endmodule

// File: rtl/mmio_tick_timer.sv
module mmio_tick_timer #(
    parameter int PRESCALE = 100,
    parameter int TW       = 32
) (
    input  logic          clk,
    input  logic          rst,
    output logic [TW-1:0] count_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    // R6
    prescale_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pre_q <= PRE_LAST);

    // R6
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1) && (pre_q == '0));
endmodule

// File: rtl/mmio_code_port.sv
module mmio_code_port #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          key_wr_i,
    input  logic          addr_wr_i,
    input  logic          data_wr_i,
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [31:0]   key_value_i,
    output logic          pm_we_o,
    output logic [1:0]    pm_size_o,
    output logic [AW-1:0] pm_addr_o,
    output logic [DW-1:0] pm_wdata_o
);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic          unlock_q;
    logic [AW-1:0] wa_q;
    logic          fire;

    assign fire = data_wr_i && unlock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q   <= 1'b0;
            wa_q       <= '0;
            pm_we_o    <= 1'b0;
            pm_size_o  <= '0;
            pm_addr_o  <= '0;
            pm_wdata_o <= '0;
        end else begin
            pm_we_o <= fire;
            if (key_wr_i)
                unlock_q <= (32'(wdata_i) == key_value_i);
            if (addr_wr_i)
                wa_q <= AW'(wdata_i);
            else if (fire)
                wa_q <= wa_q + STEP;
            if (fire) begin
                pm_addr_o  <= wa_q;
                pm_wdata_o <= wdata_i;
                pm_size_o  <= size_i;
            end
        end
    end

    // R4
    code_wr_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        pm_we_o |-> $past(unlock_q));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pm_we_o && !$past(addr_wr_i)) |-> (wa_q == pm_addr_o + STEP));

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!unlock_q && !addr_wr_i) |=> $stable(wa_q));
endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder
    import mmio_dec_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int PRESCALE = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid_i,
    input  logic              cpu_we_i,
    input  logic [1:0]        cpu_size_i,
    input  logic [AW-1:0]     cpu_addr_i,
    input  logic [DW-1:0]     cpu_wdata_i,
    output logic [DW-1:0]     cpu_rdata_o,
    output logic              ram_en_o,
    output logic              ram_we_o,
    output logic [1:0]        ram_size_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic [DW-1:0]     ram_wdata_o,
    input  logic [DW-1:0]     ram_rdata_i,
    output logic              pm_we_o,
    output logic [1:0]        pm_size_o,
    output logic [AW-1:0]     pm_addr_o,
    output logic [DW-1:0]     pm_wdata_o,
    output logic              con_tx_valid_o,
    output logic [7:0]        con_tx_byte_o,
    input  logic [7:0]        con_rx_byte_i,
    output logic              con_rx_take_o,
    output logic [DW-1:0]     debug_o,
    output logic              halt_o,
    output logic              illegal_o
);
    req_t    req;
    target_e tgt;
    logic    is_load, is_store;
    logic [DW-1:0] timer_val;
    logic    unused_hi;

    assign unused_hi = ^cpu_addr_i[AW-1:LOC_W];

    always_comb begin
        req.valid = cpu_valid_i;
        req.we    = cpu_we_i;
        req.size  = cpu_size_i;
        req.loc   = cpu_addr_i[LOC_W-1:0];
        req.data  = 32'(cpu_wdata_i);
    end

    mmio_decode u_dec (
        .req      (req),
        .tgt      (tgt),
        .is_load  (is_load),
        .is_store (is_store)
    );

    mmio_tick_timer #(.PRESCALE(PRESCALE), .TW(DW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .count_o (timer_val)
    );

    mmio_code_port #(.AW(AW), .DW(DW)) u_code (
        .clk         (clk),
        .rst         (rst),
        .key_wr_i    (is_store && tgt == TGT_KEY),
        .addr_wr_i   (is_store && tgt == TGT_CW_ADDR),
        .data_wr_i   (is_store && tgt == TGT_CW_DATA),
        .size_i      (cpu_size_i),
        .wdata_i     (cpu_wdata_i),
        .key_value_i (CODE_KEY),
        .pm_we_o     (pm_we_o),
        .pm_size_o   (pm_size_o),
        .pm_addr_o   (pm_addr_o),
        .pm_wdata_o  (pm_wdata_o)
    );

    // RAM path: combinational pass-through
    always_comb begin
        ram_en_o    = cpu_valid_i && (tgt == TGT_RAM);
        ram_we_o    = ram_en_o && cpu_we_i;
        ram_size_o  = cpu_size_i;
        ram_addr_o  = cpu_addr_i[RAM_AW-1:0];
        ram_wdata_o = cpu_wdata_i;
    end

    // Load data mux
    always_comb begin
        cpu_rdata_o   = '0;
        con_rx_take_o = 1'b0;
        if (is_load) begin
            case (tgt)
                TGT_RAM:     cpu_rdata_o = ram_rdata_i;
                TGT_CONSOLE: begin
                    cpu_rdata_o   = DW'(con_rx_byte_i);
                    con_rx_take_o = 1'b1;
                end
                TGT_TIMER:   cpu_rdata_o = timer_val;
                default:     cpu_rdata_o = '0;
            endcase
        end
    end

    // Registered IO side effects
    always_ff @(posedge clk) begin
        if (rst) begin
            con_tx_valid_o <= 1'b0;
            con_tx_byte_o  <= '0;
            debug_o        <= '0;
            halt_o         <= 1'b0;
            illegal_o      <= 1'b0;
        end else begin
            con_tx_valid_o <= is_store && tgt == TGT_CONSOLE;
            if (is_store && tgt == TGT_CONSOLE)
                con_tx_byte_o <= cpu_wdata_i[7:0];
            if (is_store && tgt == TGT_DEBUG)
                debug_o <= cpu_wdata_i;
            if (is_store && tgt == TGT_EXIT)
                halt_o <= 1'b1;
            illegal_o <= is_load && !(tgt == TGT_RAM || tgt == TGT_CONSOLE
                                      || tgt == TGT_TIMER);
        end
    end

    // R14
    io_no_ram_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid_i && cpu_addr_i[LOC_W-1]) |-> !ram_en_o);

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> halt_o);

    // R11
    illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past(cpu_valid_i && !cpu_we_i && cpu_addr_i[LOC_W-1]));

    // R7
    tx_src_chk: assert property (@(posedge clk) disable iff (rst)
        con_tx_valid_o |-> $past(cpu_valid_i && cpu_we_i));
endmodule

// File: tb/mmio_decoder_test.sv
`timescale 1ns/1ps
module mmio_decoder_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        cpu_valid = 0, cpu_we = 0;
    logic [1:0]  cpu_size = 2'd2;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0;
    logic [31:0] cpu_rdata;
    logic        ram_en, ram_we;
    logic [1:0]  ram_size;
    logic [15:0] ram_addr;
    logic [31:0] ram_wdata, ram_rdata;
    logic        pm_we;
    logic [1:0]  pm_size;
    logic [31:0] pm_addr, pm_wdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic [7:0]  rx_byte = 8'h5A;
    logic        rx_take;
    logic [31:0] dbg;
    logic        halt, illegal;

    int checks = 0, fails = 0;
    int ticks = 0;
    bit done = 0;

    // Snapshots of combinational outputs in the request cycle
    logic [31:0] s_rdata;
    logic        s_ram_en, s_ram_we, s_rx_take;
    logic [15:0] s_ram_addr;
    int          s_ticks;

    always #4 clk = ~clk;

    assign ram_rdata = {16'hC0DE, ram_addr};

    always @(posedge clk) begin
        if (rst) ticks <= 0;
        else     ticks <= ticks + 1;
    end

    mmio_decoder uut (
        .clk(clk), .rst(rst),
        .cpu_valid_i(cpu_valid), .cpu_we_i(cpu_we), .cpu_size_i(cpu_size),
        .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
        .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_size_o(ram_size),
        .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
        .pm_we_o(pm_we), .pm_size_o(pm_size), .pm_addr_o(pm_addr), .pm_wdata_o(pm_wdata),
        .con_tx_valid_o(tx_valid), .con_tx_byte_o(tx_byte),
        .con_rx_byte_i(rx_byte), .con_rx_take_o(rx_take),
        .debug_o(dbg), .halt_o(halt), .illegal_o(illegal)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One request: drive at negedge, snapshot, cross the edge, return at next negedge
    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd);
        cpu_valid = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        #1;
        s_rdata = cpu_rdata; s_ram_en = ram_en; s_ram_we = ram_we;
        s_ram_addr = ram_addr; s_rx_take = rx_take; s_ticks = ticks;
        @(posedge clk); @(negedge clk);
        cpu_valid = 0; cpu_we = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R13 pm_we", {31'b0, pm_we}, 0);
        check("R13 tx_valid", {31'b0, tx_valid}, 0);
        check("R13 halt", {31'b0, halt}, 0);
        check("R13 illegal", {31'b0, illegal}, 0);
        check("R13 debug", dbg, 0);
    endtask

    task automatic t_ram();
        access(1, 32'h0000_1234, 32'h1111_2222);
        check("R1 store ram_en", {31'b0, s_ram_en}, 1);
        check("R1 store ram_we", {31'b0, s_ram_we}, 1);
        check("R1 store ram_addr", {16'b0, s_ram_addr}, 32'h1234);
        access(0, 32'hFFFE_0040, 0);
        check("R1 high bits ignored ram_en", {31'b0, s_ram_en}, 1);
        check("R1 load ram_we", {31'b0, s_ram_we}, 0);
        check("R1 load rdata", s_rdata, 32'hC0DE_0040);
        check("R11 no illegal on ram", {31'b0, illegal}, 0);
    endtask

    task automatic t_console();
        access(1, 32'hABC1_0000, 32'h1234_5678);
        check("R14 console no ram", {31'b0, s_ram_en}, 0);
        check("R7 tx_valid", {31'b0, tx_valid}, 1);
        check("R7 tx_byte", {24'b0, tx_byte}, 32'h78);
        idle(1);
        check("R7 tx pulse ends", {31'b0, tx_valid}, 0);
        access(0, 32'h0001_0000, 0);
        check("R8 rx rdata", s_rdata, 32'h5A);
        check("R8 rx_take", {31'b0, s_rx_take}, 1);
        check("R8 no illegal", {31'b0, illegal}, 0);
    endtask

    task automatic t_debug();
        access(1, 32'h0001_FFF8, 32'hDEAD_BEEF);
        check("R10 debug capture", dbg, 32'hDEAD_BEEF);
    endtask

    task automatic t_illegal();
        access(0, 32'h0001_FC80, 0);
        check("R11 illegal key read", {31'b0, illegal}, 1);
        check("R11 rdata zero", s_rdata, 0);
        check("R14 io no ram", {31'b0, s_ram_en}, 0);
        idle(1);
        check("R11 illegal pulse ends", {31'b0, illegal}, 0);
        access(0, 32'h0001_2345, 0);
        check("R11 illegal unknown", {31'b0, illegal}, 1);
    endtask

    task automatic t_ignored();
        access(1, 32'h0001_ABCD, 32'h5555_AAAA);
        check("R12 debug kept", dbg, 32'hDEAD_BEEF);
        check("R12 no tx", {31'b0, tx_valid}, 0);
        check("R12 no pm_we", {31'b0, pm_we}, 0);
        check("R12 no halt", {31'b0, halt}, 0);
        access(1, 32'h0001_FFF4, 32'hFFFF_0000);
        access(0, 32'h0001_FFF4, 0);
        check("R12 timer unaffected", s_rdata, 32'(s_ticks / 100));
    endtask

    task automatic t_code();
        // locked since reset
        access(1, 32'h0001_FC88, 32'h0BAD_0000);
        check("R5 locked no pm_we", {31'b0, pm_we}, 0);
        access(1, 32'h0001_FC80, 32'h1337_F7D1);
        access(1, 32'h0001_FC88, 32'hA1A1_A1A1);
        check("R2 unlocked write", {31'b0, pm_we}, 1);
        check("R5 addr not advanced while locked", pm_addr, 32'h0);
        check("R4 data", pm_wdata, 32'hA1A1_A1A1);
        check("R4 size", {30'b0, pm_size}, 2);
        idle(1);
        check("R4 single pulse", {31'b0, pm_we}, 0);
        access(1, 32'h0001_FC84, 32'h0000_2000);
        check("R3 addr load no write", {31'b0, pm_we}, 0);
        access(1, 32'h0001_FC88, 32'hB2B2_0001);
        check("R3 loaded address", pm_addr, 32'h2000);
        access(1, 32'h0001_FC88, 32'hB2B2_0002);
        check("R4 back-to-back we", {31'b0, pm_we}, 1);
        check("R4 step by 4", pm_addr, 32'h2004);
        access(1, 32'h0001_FC80, 32'h1337_F7D0);
        access(1, 32'h0001_FC88, 32'hC3C3_C3C3);
        check("R2 wrong key relocks", {31'b0, pm_we}, 0);
        access(1, 32'h0001_FC80, 32'h1337_F7D1);
        access(1, 32'h0001_FC88, 32'hD4D4_D4D4);
        check("R5 dropped store kept address", pm_addr, 32'h2008);
    endtask

    task automatic t_timer();
        while (ticks < 250) @(negedge clk);
        access(0, 32'h0001_FFF4, 0);
        check("R6 timer value", s_rdata, 32'(s_ticks / 100));
        while ((ticks % 100) != 99) @(negedge clk);
        access(0, 32'h0001_FFF4, 0);
        check("R6 read on wrap edge", s_rdata, 32'(s_ticks / 100));
        access(0, 32'h0001_FFF4, 0);
        check("R6 read after wrap", s_rdata, 32'(s_ticks / 100));
        check("R6 no illegal", {31'b0, illegal}, 0);
    endtask

    task automatic t_halt();
        access(1, 32'h0001_FFFC, 0);
        check("R9 halt set", {31'b0, halt}, 1);
        idle(3);
        check("R9 halt sticky", {31'b0, halt}, 1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ram();
        t_console();
        t_debug();
        t_illegal();
        t_ignored();
        t_code();
        t_timer();
        t_halt();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule